// File: doc/BRIEF.md
# Self-Test Wrapper for a Small Combinational Block

This wrapper surrounds a four-input combinational circuit and lets it test itself without outside equipment. In normal operation the system inputs pass straight into the circuit, and its outputs are driven onto the system outputs. When the test-enable input goes high, a four-bit pseudo-random generator takes over the circuit's inputs. The generator steps through every non-zero four-bit value exactly once. Each response the circuit produces is folded into a multiple-input signature register.

After the fifteenth pattern, the controller stops compaction and raises a done flag. It also drives a good flag, which is high only when the final signature equals a golden value fixed by a parameter. Dropping test-enable sends the wrapper back to idle and restores the system path on the next clock. The circuit under test is a placeholder with a configurable output width. Its outputs stay visible during a run, so each pattern can be watched at the ports.

Top module: `lbist_wrap`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first cycle after it, done and good are 0 and the system path is selected.
- R2: In idle, output bit i equals a[i mod 4] XOR (a[(i+1) mod 4] AND a[(i+2) mod 4]), where a is the 4-bit system input.
- R3: During a run, the circuit is fed from the generator. The first pattern is 0001, written with bit 3 on the left. Each step shifts right, and the new bit 3 is the XOR of bits 1 and 0. The pattern is never all zero.
- R4: A run applies exactly 15 patterns. Done rises after the 16th rising edge, counted from the first edge that samples test-enable high.
- R5: The signature starts at 0. Each applied response y updates it to {s[1]^s[0], s[W-1:1]} XOR y. Good is 1 at done only if the final signature equals the parameter GOLDEN (default 4'b0111).
- R6: Good is 0 whenever done is 0.
- R7: While test-enable stays high after done, done stays 1 and good stays unchanged.
- R8: Test-enable low at a rising edge returns the wrapper to idle on that edge: done drops to 0 and the system path returns. Raising test-enable again restarts the run from pattern 0001.
- R9: The system inputs have no effect on the outputs or the signature during a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Starts and holds a self-test run |
| sys_in | input | 4 | System inputs to the circuit |
| sys_out | output | OUT_W | Circuit outputs |
| bist_done | output | 1 | Run finished |
| bist_good | output | 1 | Final signature matched the golden value; valid while done is high |

## Verification
A generator that skips or repeats a state shows up at sys_out on the very next cycle of a run, because the circuit's outputs are visible at every pattern. A miscounted run length moves the done edge away from the 16th clock, where the bench samples it. A corrupted signature register only becomes visible at done, as a wrong good flag. To catch that case, two copies of the wrapper with different golden values must give opposite verdicts.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int PG_W  = 4;
    localparam int NPAT  = (1 << PG_W) - 1;
    localparam int CNT_W = $clog2(NPAT + 1);
    localparam logic [PG_W-1:0] PG_SEED = 4'b0001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } bist_st_e;

    typedef struct packed {
        logic sel_pat;
        logic step;
        logic clear;
        logic done;
    } bist_ctl_s;

    function automatic logic [PG_W-1:0] pg_next(input logic [PG_W-1:0] s);
        return {s[1] ^ s[0], s[PG_W-1:1]};
    endfunction

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
    import lbist_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    output logic [PG_W-1:0] pat
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            pat <= PG_SEED;
        end else if (step) begin
            pat <= pg_next(pat);
        end
    end
endmodule

// File: rtl/lbist_cut.sv
module lbist_cut
    import lbist_pkg::*;
#(
    parameter int OUT_W = 4
) (
    input  logic [PG_W-1:0]  a,
    output logic [OUT_W-1:0] y
);
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        localparam int I0 = i % PG_W;
        localparam int I1 = (i + 1) % PG_W;
        localparam int I2 = (i + 2) % PG_W;
        assign y[i] = a[I0] ^ (a[I1] & a[I2]);
    end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] sig
);
    logic [W-1:0] sig_nxt;

    always_comb begin
        sig_nxt = {sig[1] ^ sig[0], sig[W-1:1]} ^ d;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sig <= '0;
        end else if (en) begin
            sig <= sig_nxt;
        end
    end
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      test_en,
    output bist_ctl_s ctl
);
    bist_st_e         state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (test_en) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (!test_en) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(NPAT - 1)) state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (!test_en) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.sel_pat = (state != ST_IDLE);
        ctl.step    = (state == ST_RUN) && test_en;
        ctl.clear   = (state == ST_IDLE);
        ctl.done    = (state == ST_DONE);
    end
endmodule

// File: rtl/lbist_wrap.sv
module lbist_wrap
    import lbist_pkg::*;
#(
    parameter int               OUT_W  = 4,
    parameter logic [OUT_W-1:0] GOLDEN = 4'b0111
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_en,
    input  logic [PG_W-1:0]  sys_in,
    output logic [OUT_W-1:0] sys_out,
    output logic             bist_done,
    output logic             bist_good
);
    bist_ctl_s        ctl;
    logic [PG_W-1:0]  pg_pat;
    logic [PG_W-1:0]  cut_in;
    logic [OUT_W-1:0] cut_y;
    logic [OUT_W-1:0] sig;
    logic             path_sel;

    lbist_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .test_en (test_en),
        .ctl     (ctl)
    );

    lbist_prpg u_prpg (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.clear),
        .step (ctl.step),
        .pat  (pg_pat)
    );

    assign path_sel = ctl.sel_pat;
    assign cut_in   = path_sel ? pg_pat : sys_in;

    lbist_cut #(.OUT_W(OUT_W)) u_cut (
        .a (cut_in),
        .y (cut_y)
    );

    lbist_misr #(.W(OUT_W)) u_misr (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.clear),
        .en    (ctl.step),
        .d     (cut_y),
        .sig   (sig)
    );

    assign sys_out   = cut_y;
    assign bist_done = ctl.done;
    assign bist_good = ctl.done && (sig == GOLDEN);
endmodule

// File: rtl/lbist_wrap_chk.sv
module lbist_wrap_chk
    import lbist_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            test_en,
    input logic            bist_done,
    input logic            bist_good,
    input logic            path_sel,
    input logic [PG_W-1:0] pg_pat
);
    logic [4:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !test_en) begin
            run_len <= '0;
        end else if (run_len != 5'd31) begin
            run_len <= run_len + 1'b1;
        end
    end

    p_good_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !bist_done |-> !bist_good);

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> (!bist_done && !path_sel));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (bist_done && test_en) |=> (bist_done && $stable(bist_good)));

    p_pat_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        path_sel |-> (pg_pat != '0));

    p_run_len_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bist_done) |-> (run_len == 5'(NPAT + 1)));
endmodule

bind lbist_wrap lbist_wrap_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .test_en   (test_en),
    .bist_done (bist_done),
    .bist_good (bist_good),
    .path_sel  (path_sel),
    .pg_pat    (pg_pat)
);

// File: tb/tb_lbist_wrap.sv
module tb_lbist_wrap;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_en = 1'b0;
    logic [3:0] sys_in = 4'h0;
    logic [3:0] sys_out, sys_out_b;
    logic       done, good, done_b, good_b;
    int         errors = 0;
    int         checks = 0;
    logic [3:0] sig_m;

    localparam logic [3:0] PAT_TBL [15] = '{
        4'b0001, 4'b1000, 4'b0100, 4'b0010, 4'b1001,
        4'b1100, 4'b0110, 4'b1011, 4'b0101, 4'b1010,
        4'b1101, 4'b1110, 4'b1111, 4'b0111, 4'b0011
    };

    always #2 clk = ~clk;

    lbist_wrap dut (
        .clk(clk), .rst(rst), .test_en(test_en), .sys_in(sys_in),
        .sys_out(sys_out), .bist_done(done), .bist_good(good)
    );

    lbist_wrap #(.GOLDEN(4'b1000)) dut_bad (
        .clk(clk), .rst(rst), .test_en(test_en), .sys_in(sys_in),
        .sys_out(sys_out_b), .bist_done(done_b), .bist_good(good_b)
    );

    function automatic logic [3:0] cut_m(input logic [3:0] a);
        logic [3:0] y;
        for (int i = 0; i < 4; i++)
            y[i] = a[i % 4] ^ (a[(i + 1) % 4] & a[(i + 2) % 4]);
        return y;
    endfunction

    function automatic logic [3:0] misr_m(input logic [3:0] s, input logic [3:0] y);
        return {s[1] ^ s[0], s[3:1]} ^ y;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic full_run(input bit vary_in);
        @(negedge clk);
        test_en = 1'b1;
        sig_m = 4'h0;
        @(posedge clk);
        for (int j = 0; j < 15; j++) begin
            @(negedge clk);
            if (vary_in) sys_in = 4'(j * 7 + 3);
            #0.5;
            chk(sys_out == cut_m(PAT_TBL[j]), "R3", sys_out, cut_m(PAT_TBL[j]));
            chk(done == 1'b0, "R4", done, 0);
            chk(good == 1'b0, "R6", good, 0);
            sig_m = misr_m(sig_m, cut_m(PAT_TBL[j]));
            @(posedge clk);
        end
        @(negedge clk);
        chk(done == 1'b1, "R4", done, 1);
        chk(good == (sig_m == 4'b0111), "R5", good, (sig_m == 4'b0111));
        chk(good_b == (sig_m == 4'b1000), "R5", good_b, (sig_m == 4'b1000));
        chk(sig_m == 4'b0111, "R9", sig_m, 4'b0111);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic g0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        sys_in = 4'b0110;
        #0.5;
        chk(done == 1'b0 && good == 1'b0, "R1", {done, good}, 0);
        chk(sys_out == cut_m(4'b0110), "R1", sys_out, cut_m(4'b0110));
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1", done, 0);

        // R2: system path over every input value
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            sys_in = 4'(a);
            #0.5;
            chk(sys_out == cut_m(4'(a)), "R2", sys_out, cut_m(4'(a)));
        end

        // R3 R4 R5 R9: full run with changing system inputs
        full_run(1'b1);

        // R7: hold after done
        g0 = good;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            sys_in = 4'(k + 9);
            #0.5;
            chk(done == 1'b1 && good == g0, "R7", {done, good}, {1'b1, g0});
        end

        // R8: drop test_en after done
        @(negedge clk);
        test_en = 1'b0;
        sys_in = 4'b1011;
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0 && good == 1'b0, "R8", {done, good}, 0);
        chk(sys_out == cut_m(4'b1011), "R8", sys_out, cut_m(4'b1011));

        // R8: abort mid-run, then restart from the seed
        @(negedge clk);
        test_en = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        test_en = 1'b0;
        sys_in = 4'b1100;
        @(posedge clk);
        @(negedge clk);
        chk(sys_out == cut_m(4'b1100), "R8", sys_out, cut_m(4'b1100));
        chk(done == 1'b0, "R8", done, 0);
        test_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(sys_out == cut_m(4'b0001), "R8", sys_out, cut_m(4'b0001));
        test_en = 1'b0;
        @(posedge clk);

        // R9: constant system input gives the same verdict
        @(negedge clk);
        sys_in = 4'b1111;
        full_run(1'b0);
        @(negedge clk);
        test_en = 1'b0;

        // R1: reset in the middle of a run
        @(negedge clk);
        test_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        sys_in = 4'b0101;
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0 && sys_out == cut_m(4'b0101), "R1", sys_out, cut_m(4'b0101));
        rst = 1'b0;
        test_en = 1'b0;
        @(posedge clk);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule